// File: doc/BRIEF.md
# CAN Interrupt and Status Flag Unit

This block collects the events that a CAN controller reports to software and holds them as sticky flags. The receive path supplies a pulse each time a finished frame lands in the foreground receive buffer and a pulse each time a frame completes. A separate level says whether the receive FIFO was full when that frame completed. The bus monitor reports activity on the wire. The error-counter logic supplies the current receive and transmit error counts, which the block turns into two 2-bit bus-state fields. The transmit side reports one completion pulse per transmit buffer.

Software reaches the block through a small register port. It reads the flags, the bus-state fields and the enables there, and it clears flags by writing ones. A flag can be cleared only when its cause is absent in that cycle. Four interrupt lines leave the block: receive, transmit, error and wake-up. Each line stays high while any enabled flag of its group is set. Clearing the receive-full flag also tells the FIFO that the foreground buffer is free, so that the next waiting frame can move in.

Top module: `can_irq_flags`

## Requirements
- R1: Register map, 2-bit address: 0 = receive flags, 1 = receive enables, 2 = transmit flags, 3 = transmit enables. In the receive flag byte, bit 0 is receive-full, bit 1 is overrun and bit 2 is status-change. Bits 4:3 hold the transmit bus state, bits 6:5 hold the receive bus state, and bit 7 is wake-up. Writing 1 to a flag bit at address 0 or 2 clears that flag. A 0 in the written data leaves that flag unchanged.
- R2: When a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R3: A flag whose cause is active in the cycle of a clear write stays set. The wake-up cause is a level and can hold a flag up for many cycles.
- R4: irq_rx follows receive-full AND its enable. irq_err follows (overrun AND its enable) OR (status-change AND its enable). irq_wake follows wake-up AND its enable. irq_tx is high while any transmit flag is set together with its enable. The enables sit at the same bit positions as their flags.
- R5: A pulse on rx_fg_load sets receive-full one cycle later. A write that clears a set receive-full flag pulses rx_release in that same cycle. The next rx_fg_load sets the flag again.
- R6: A pulse on rx_frame_done while rx_fifo_full is 1 sets the overrun flag. While rx_fifo_full is 0, the same pulse does not set it.
- R7: bus_activity sets the wake-up flag only while sleep_req, sleep_ack and wake_en are all 1. irq_wake additionally requires the wake-up enable (bit 7 at address 1).
- R8: Transmit bus state encoding: 00 below 96, 01 from 96 to 127, 10 from 128 to 255, 11 above 255. The field reflects the counter one cycle after the counter changes.
- R9: The receive bus state uses the same thresholds but saturates at 10 and never shows 11.
- R10: Any change of either bus-state field sets the status-change flag in the same cycle that the new field value appears.
- R11: Transmit flag i, at bit i of address 2, sets on tx_done[i]. Each transmit flag clears on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fg_load | input | 1 | Frame moved into foreground receive buffer |
| rx_frame_done | input | 1 | A received frame completed |
| rx_fifo_full | input | 1 | Receive FIFO had no free slot |
| bus_activity | input | 1 | Activity seen on the CAN bus |
| sleep_req | input | 1 | Sleep requested |
| sleep_ack | input | 1 | Sleep acknowledged |
| wake_en | input | 1 | Wake-up on bus activity enabled |
| tx_done | input | N_TX | Per-buffer transmit completion pulses |
| rx_err_cnt | input | CNT_W | Receive error counter |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| rx_release | output | 1 | Foreground buffer released by software |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_wake | output | 1 | Wake-up interrupt |

## Verification
The hardest situations to reach are a clear that collides with a set, and a clear attempted while the cause is still present. The bench drives the write strobe and the event input in the very same cycle to create the collision. It holds bus_activity high across a clear write to test a persisting cause. It also sweeps every transmit counter value from 0 to 511 and every receive counter value from 0 to 300. At each step it compares both bus-state fields and the status-change flag against thresholds computed in the bench, then clears the flag to set up the next step.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    typedef enum logic [1:0] {
        BUS_OK      = 2'b00,
        BUS_WARN    = 2'b01,
        BUS_PASSIVE = 2'b10,
        BUS_OFF     = 2'b11
    } bus_state_e;

    typedef enum logic [1:0] {
        ADDR_RXFLG = 2'd0,
        ADDR_RXIE  = 2'd1,
        ADDR_TXFLG = 2'd2,
        ADDR_TXIE  = 2'd3
    } reg_addr_e;

    localparam int REG_W = 8;

    // Index of each receive-group flag inside the internal 4-bit bank
    localparam int RF_FULL = 0;
    localparam int RF_OVR  = 1;
    localparam int RF_STAT = 2;
    localparam int RF_WAKE = 3;
    localparam int RF_N    = 4;

    // Software-visible view of the receive flag byte
    typedef struct packed {
        logic       wake;
        bus_state_e rstat;
        bus_state_e tstat;
        logic       stat_chg;
        logic       ovr;
        logic       full;
    } rx_view_t;

    function automatic bus_state_e classify(input int unsigned cnt,
                                            input bit          tx_side,
                                            input int unsigned warn_lim,
                                            input int unsigned passive_lim,
                                            input int unsigned busoff_lim);
        if (tx_side && cnt >= busoff_lim) return BUS_OFF;
        if (cnt >= passive_lim)           return BUS_PASSIVE;
        if (cnt >= warn_lim)              return BUS_WARN;
        return BUS_OK;
    endfunction

endpackage

// File: rtl/can_w1c_bank.sv
module can_w1c_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= 1'b0;
            else if (set_i[i]) q[i] <= 1'b1;   // cause present: set wins
            else if (clr_i[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/can_err_state.sv
module can_err_state
    import can_irq_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    output bus_state_e       rstat,
    output bus_state_e       tstat,
    output logic             changed
);
    localparam int SIDES = 2;

    logic [CNT_W-1:0] cnt [SIDES];
    bus_state_e       now_st [SIDES];
    bus_state_e       reg_st [SIDES];
    logic [SIDES-1:0] diff;

    assign cnt[0] = rx_cnt;
    assign cnt[1] = tx_cnt;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        always_comb begin
            now_st[s] = classify(32'(cnt[s]), (s == 1), WARN_LIM, PASSIVE_LIM, BUSOFF_LIM);
        end
        assign diff[s] = (now_st[s] != reg_st[s]);
        always_ff @(posedge clk) begin
            if (rst) reg_st[s] <= BUS_OK;
            else     reg_st[s] <= now_st[s];
        end
    end

    assign rstat   = reg_st[0];
    assign tstat   = reg_st[1];
    assign changed = |diff;
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
#(
    parameter int N_TX        = 3,
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_fg_load,
    input  logic             rx_frame_done,
    input  logic             rx_fifo_full,
    input  logic             bus_activity,
    input  logic             sleep_req,
    input  logic             sleep_ack,
    input  logic             wake_en,
    input  logic [N_TX-1:0]  tx_done,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             rx_release,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_err,
    output logic             irq_wake
);
    localparam int WAKE_BIT = REG_W - 1;

    bus_state_e       rstat, tstat;
    logic             stat_chg;
    logic [RF_N-1:0]  rx_set, rx_clr, rx_flags, rx_ie;
    logic [N_TX-1:0]  tx_clr, tx_flags, tx_ie;
    logic             wr_rxflg, wr_rxie, wr_txflg, wr_txie;
    logic             wake_cause;
    rx_view_t         rx_view;

    can_err_state #(
        .CNT_W(CNT_W), .WARN_LIM(WARN_LIM),
        .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
    ) u_state (
        .clk(clk), .rst(rst),
        .rx_cnt(rx_err_cnt), .tx_cnt(tx_err_cnt),
        .rstat(rstat), .tstat(tstat), .changed(stat_chg)
    );

    assign wr_rxflg = wr_en && (addr == ADDR_RXFLG);
    assign wr_rxie  = wr_en && (addr == ADDR_RXIE);
    assign wr_txflg = wr_en && (addr == ADDR_TXFLG);
    assign wr_txie  = wr_en && (addr == ADDR_TXIE);

    assign wake_cause = bus_activity && sleep_req && sleep_ack && wake_en;

    always_comb begin
        rx_set           = '0;
        rx_set[RF_FULL]  = rx_fg_load;
        rx_set[RF_OVR]   = rx_frame_done && rx_fifo_full;
        rx_set[RF_STAT]  = stat_chg;
        rx_set[RF_WAKE]  = wake_cause;
        rx_clr           = '0;
        if (wr_rxflg) begin
            rx_clr[RF_FULL] = wdata[0];
            rx_clr[RF_OVR]  = wdata[1];
            rx_clr[RF_STAT] = wdata[2];
            rx_clr[RF_WAKE] = wdata[WAKE_BIT];
        end
        tx_clr = wr_txflg ? wdata[N_TX-1:0] : '0;
    end

    can_w1c_bank #(.W(RF_N)) u_rxbank (
        .clk(clk), .rst(rst), .set_i(rx_set), .clr_i(rx_clr), .q(rx_flags)
    );

    can_w1c_bank #(.W(N_TX)) u_txbank (
        .clk(clk), .rst(rst), .set_i(tx_done), .clr_i(tx_clr), .q(tx_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ie <= '0;
            tx_ie <= '0;
        end else begin
            if (wr_rxie) rx_ie <= {wdata[WAKE_BIT], wdata[2:0]};
            if (wr_txie) tx_ie <= wdata[N_TX-1:0];
        end
    end

    assign rx_release = wr_rxflg && wdata[0] && rx_flags[RF_FULL] && !rx_fg_load;

    always_comb begin
        rx_view.wake     = rx_flags[RF_WAKE];
        rx_view.rstat    = rstat;
        rx_view.tstat    = tstat;
        rx_view.stat_chg = rx_flags[RF_STAT];
        rx_view.ovr      = rx_flags[RF_OVR];
        rx_view.full     = rx_flags[RF_FULL];
        rdata = '0;
        unique case (addr)
            ADDR_RXFLG: rdata = rx_view;
            ADDR_RXIE:  rdata = {rx_ie[RF_WAKE], 4'b0000, rx_ie[2:0]};
            ADDR_TXFLG: for (int i = 0; i < N_TX; i++) rdata[i] = tx_flags[i];
            default:    for (int i = 0; i < N_TX; i++) rdata[i] = tx_ie[i];
        endcase
    end

    assign irq_rx   = rx_flags[RF_FULL] && rx_ie[RF_FULL];
    assign irq_err  = (rx_flags[RF_OVR] && rx_ie[RF_OVR]) || (rx_flags[RF_STAT] && rx_ie[RF_STAT]);
    assign irq_wake = rx_flags[RF_WAKE] && rx_ie[RF_WAKE];
    assign irq_tx   = |(tx_flags & tx_ie);
endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_fg_load,
    input logic       rx_frame_done,
    input logic       rx_fifo_full,
    input logic       bus_activity,
    input logic       sleep_req,
    input logic       sleep_ack,
    input logic       wake_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [3:0] rx_flags,
    input logic [1:0] rstat,
    input logic [1:0] tstat,
    input logic       irq_wake
);
    logic clr_full;
    assign clr_full = wr_en && (addr == 2'd0) && wdata[0];

    assert_w1c_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (clr_full && !rx_fg_load) |=> !rx_flags[0]);

    assert_zero_keeps_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_flags[0] && !clr_full) |=> rx_flags[0]);

    assert_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
        rx_fg_load |=> rx_flags[0]);

    assert_cause_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_activity && sleep_req && sleep_ack && wake_en) |=> rx_flags[3]);

    assert_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_frame_done && rx_fifo_full) |=> rx_flags[1]);

    assert_wake_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flags[3]) |-> $past(bus_activity && sleep_req && sleep_ack && wake_en));

    assert_wake_irq_R7: assert property (@(posedge clk) disable iff (rst)
        irq_wake |-> rx_flags[3]);

    assert_rx_no_busoff_R9: assert property (@(posedge clk) disable iff (rst)
        rstat != 2'b11);

    assert_change_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (rstat != $past(rstat) || tstat != $past(tstat)) |-> rx_flags[2]);
endmodule

bind can_irq_flags can_irq_flags_chk u_chk (
    .clk(clk), .rst(rst), .rx_fg_load(rx_fg_load), .rx_frame_done(rx_frame_done),
    .rx_fifo_full(rx_fifo_full), .bus_activity(bus_activity), .sleep_req(sleep_req),
    .sleep_ack(sleep_ack), .wake_en(wake_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rx_flags(rx_flags), .rstat(rstat), .tstat(tstat),
    .irq_wake(irq_wake)
);

// File: tb/can_irq_flags_test.sv
module can_irq_flags_test;
    localparam int N_TX  = 3;
    localparam int CNT_W = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_fg_load = 0, rx_frame_done = 0, rx_fifo_full = 0;
    logic             bus_activity = 0, sleep_req = 0, sleep_ack = 0, wake_en = 0;
    logic [N_TX-1:0]  tx_done = '0;
    logic [CNT_W-1:0] rx_err_cnt = '0, tx_err_cnt = '0;
    logic             wr_en = 0;
    logic [1:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             rx_release, irq_rx, irq_tx, irq_err, irq_wake;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    can_irq_flags #(.N_TX(N_TX), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .rx_fg_load(rx_fg_load), .rx_frame_done(rx_frame_done),
        .rx_fifo_full(rx_fifo_full), .bus_activity(bus_activity), .sleep_req(sleep_req),
        .sleep_ack(sleep_ack), .wake_en(wake_en), .tx_done(tx_done),
        .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_release(rx_release), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_err(irq_err), .irq_wake(irq_wake)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic int exp_t(input int v);
        if (v > 255) return 3;
        if (v >= 128) return 2;
        if (v >= 96) return 1;
        return 0;
    endfunction

    function automatic int exp_r(input int v);
        if (v >= 128) return 2;
        if (v >= 96) return 1;
        return 0;
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int pr, pt, er, et;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state of every register (R1)
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reset value", d, 0);
        end
        check("R4 reset irqs", {irq_rx, irq_tx, irq_err, irq_wake}, 0);

        // Receive-full and release (R5), interrupt (R4)
        wr(2'd1, 8'h07);
        @(negedge clk); rx_fg_load = 1; @(negedge clk); rx_fg_load = 0;
        rd(2'd0, d);
        check("R5 full set", d[0], 1);
        check("R4 irq_rx", irq_rx, 1);
        // Overrun set after interrupt began; must survive the full clear (R1, R6)
        @(negedge clk); rx_frame_done = 1; rx_fifo_full = 0; @(negedge clk); rx_frame_done = 0;
        rd(2'd0, d);
        check("R6 no overrun when not full", d[1], 0);
        @(negedge clk); rx_frame_done = 1; rx_fifo_full = 1; @(negedge clk); rx_frame_done = 0; rx_fifo_full = 0;
        rd(2'd0, d);
        check("R6 overrun set", d[1], 1);
        check("R4 irq_err", irq_err, 1);
        @(negedge clk);
        wr_en = 1; addr = 2'd0; wdata = 8'h01;
        #1 check("R5 release pulse", rx_release, 1);
        @(negedge clk); wr_en = 0; wdata = 0;
        rd(2'd0, d);
        check("R1 full cleared", d[0], 0);
        check("R1 overrun untouched", d[1], 1);
        check("R4 irq_rx low", irq_rx, 0);
        @(negedge clk); rx_fg_load = 1; @(negedge clk); rx_fg_load = 0;
        rd(2'd0, d);
        check("R5 next frame sets again", d[0], 1);
        wr(2'd0, 8'h02);
        rd(2'd0, d);
        check("R1 overrun cleared", d[1], 0);
        check("R1 full kept on write 0", d[0], 1);
        check("R4 irq_err low", irq_err, 0);

        // Set versus clear in one cycle (R2)
        @(negedge clk);
        rx_fg_load = 1; wr_en = 1; addr = 2'd0; wdata = 8'h01;
        #1 check("R5 no release on collision", rx_release, 0);
        @(negedge clk); rx_fg_load = 0; wr_en = 0; wdata = 0;
        rd(2'd0, d);
        check("R2 set wins", d[0], 1);
        wr(2'd0, 8'h01);

        // Wake gating sweep (R7)
        for (int c = 0; c < 16; c++) begin
            sleep_req = c[0]; sleep_ack = c[1]; wake_en = c[2];
            wr(2'd1, c[3] ? 8'h80 : 8'h00);
            @(negedge clk); bus_activity = 1; @(negedge clk); bus_activity = 0;
            rd(2'd0, d);
            check("R7 wake flag", d[7], int'(c[0] & c[1] & c[2]));
            check("R7 irq_wake", irq_wake, int'(c[0] & c[1] & c[2] & c[3]));
            wr(2'd0, 8'h80);
            rd(2'd0, d);
            check("R7 wake cleared", d[7], 0);
        end

        // Persisting cause blocks clear (R3)
        sleep_req = 1; sleep_ack = 1; wake_en = 1;
        @(negedge clk); bus_activity = 1;
        wr(2'd0, 8'h80);
        rd(2'd0, d);
        check("R3 clear ignored while active", d[7], 1);
        @(negedge clk); bus_activity = 0;
        wr(2'd0, 8'h80);
        rd(2'd0, d);
        check("R3 clear after cause gone", d[7], 0);
        sleep_req = 0; sleep_ack = 0; wake_en = 0;

        // Transmit flags (R11)
        wr(2'd3, 8'h05);
        @(negedge clk); tx_done = 3'b101; @(negedge clk); tx_done = '0;
        rd(2'd2, d);
        check("R11 tx flags set", d, 5);
        check("R4 irq_tx", irq_tx, 1);
        wr(2'd2, 8'h02);
        rd(2'd2, d);
        check("R11 clear absent bit keeps others", d, 5);
        wr(2'd2, 8'h01);
        rd(2'd2, d);
        check("R11 single clear", d, 4);
        wr(2'd3, 8'h01);
        rd(2'd2, d);
        check("R4 irq_tx masked", irq_tx, 0);
        wr(2'd2, 8'h04);

        // Counter sweeps (R8, R9, R10)
        pr = 0; pt = 0;
        for (int v = 0; v < 512 + 301; v++) begin
            @(negedge clk);
            if (v < 512) begin
                tx_err_cnt = 9'(v);
            end else begin
                tx_err_cnt = '0;
                rx_err_cnt = 9'(v - 512);
            end
            er = exp_r(int'(rx_err_cnt));
            et = exp_t(int'(tx_err_cnt));
            rd(2'd0, d);
            check("R8 tx state", int'(d[4:3]), et);
            check("R9 rx state", int'(d[6:5]), er);
            check("R10 change flag", d[2], int'((er != pr) || (et != pt)));
            wr(2'd0, 8'h04);
            pr = er; pt = et;
        end
        rx_err_cnt = 9'd511;
        rd(2'd0, d);
        rd(2'd0, d);
        check("R9 rx saturates", int'(d[6:5]), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule